// File: doc/BRIEF.md
# Single-Bus Microcoded Datapath

This block is the data side of a small microprogrammed processor. All transfers between its storage elements travel over one shared 32-bit bus, and an external sequencer supplies a flat control word every cycle. Each word says which single source drives the bus that cycle, which registers capture the bus at the next clock edge, which register-file entry is addressed, how the immediate is formed, which ALU result is produced and whether a memory access starts. One macro-instruction therefore runs as a short series of register transfers, such as: fetch address into the address register, wait for memory, capture the instruction, bump the PC, dispatch.

The datapath contains a register file with 32 general registers plus the PC, two ALU operand latches (A and B), a memory address register, an instruction register, an immediate former and a slow word memory. It reports the instruction opcode, a flag telling whether latch A is zero, and the memory busy flag back to the sequencer. A host port gives a fifth bus source, used to bootstrap state and to inject data. The bus is observable for checking.

There is no valid/ready flow control at this boundary: the only back-pressure is `mem_busy`. While it is high the sequencer must hold off further memory requests, which are dropped, and must not take memory data from the bus.

Top module: `ubus_datapath`

## Requirements
- R1: After reset all registers, the PC, A, B, the address register and the instruction register hold 0; `mem_busy` is low; `a_zero` is high; the bus reads 0 when no driver is enabled.
- R2: The bus carries the value of the one enabled source (memory read data, register file, ALU, immediate, host), and 0 when none is enabled; two enables at once is illegal.
- R3: `cap_a`, `cap_b`, `cap_ma` and `cap_ir` load the bus value into A, B, the address register and the instruction register at the clock edge that ends the cycle.
- R4: `reg_sel` picks the entry: 0 = IR bits 25:21, 1 = IR bits 20:16, 2 = IR bits 15:11, 3 = the PC (entry 32), 4 = link register 31, 5 to 7 = entry 0. `reg_wr` writes the bus into that entry.
- R5: Entry 0 always reads 0; writes to it have no effect.
- R6: `imm_sel` forms the immediate from IR bits 15:0: 0 = sign-extended, 1 = zero-extended, 2 = sign-extended then shifted left by 2, 3 = jump target {A[31:28], B[25:0], 2'b00}.
- R7: `alu_op`: 0 = A+B, 1 = A, 2 = B, 3 = IR-decoded operation. When IR bits 31:26 are 0 the function field IR[5:0] decodes 0x20 add, 0x22 subtract A-B, 0x24 and, 0x25 or, 0x26 xor, 0x2A signed set-less-than; otherwise the opcode decodes 0x08 add, 0x0C and, 0x0D or, 0x0E xor, 0x0A signed set-less-than. Any other code adds.
- R8: `a_zero` is high exactly when latch A holds 0.
- R9: A memory request accepted while not busy keeps `mem_busy` high for MEM_LAT cycles; the word address is address register bits 11:2 (the low two bits ignored), and write data is the bus value in the request cycle. Requests made while busy are ignored.
- R10: After a read, once `mem_busy` is low, enabling `drv_mem` puts the addressed word on the bus.
- R11: `opcode` presents IR bits 31:26.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drv_mem | input | 1 | Memory read data drives the bus |
| drv_reg | input | 1 | Selected register-file entry drives the bus |
| drv_alu | input | 1 | ALU result drives the bus |
| drv_imm | input | 1 | Formed immediate drives the bus |
| drv_host | input | 1 | Host data drives the bus |
| host_data | input | 32 | Host bus value |
| cap_a | input | 1 | Load A from the bus |
| cap_b | input | 1 | Load B from the bus |
| cap_ma | input | 1 | Load memory address register from the bus |
| cap_ir | input | 1 | Load instruction register from the bus |
| reg_sel | input | 3 | Register-file index source |
| reg_wr | input | 1 | Write bus into selected entry |
| imm_sel | input | 2 | Immediate form |
| alu_op | input | 2 | ALU operation |
| mem_req | input | 1 | Start a memory access |
| mem_we | input | 1 | Access is a write (1) or read (0) |
| opcode | output | 6 | Instruction opcode field |
| a_zero | output | 1 | Latch A equals zero |
| mem_busy | output | 1 | Memory access in progress |
| bus | output | 32 | Current shared bus value |

## Verification
On every cycle the assertions check that at most one bus driver is enabled, that busy only rises after a request, that the latched memory address holds through an access, that a PC write lands in the PC entry and that the opcode follows the captured instruction. Only the bench's scenarios show the register-select mapping over all 32 indices, the zero register, each immediate form, the ALU decode table including signed compare and the default, the exact busy length, ignoring of a request made while busy, and read-back of written words with the low address bits ignored.

// File: rtl/ubus_pkg.sv
`timescale 1ns/1ps
package ubus_pkg;
  typedef enum logic [1:0] {
    ALU_ADD  = 2'd0,
    ALU_A    = 2'd1,
    ALU_B    = 2'd2,
    ALU_IR   = 2'd3
  } alu_op_e;

  typedef enum logic [1:0] {
    IMM_SEXT   = 2'd0,
    IMM_ZEXT   = 2'd1,
    IMM_SEXT4  = 2'd2,
    IMM_JUMP   = 2'd3
  } imm_sel_e;

  localparam logic [2:0] RSEL_RS   = 3'd0;
  localparam logic [2:0] RSEL_RT   = 3'd1;
  localparam logic [2:0] RSEL_RD   = 3'd2;
  localparam logic [2:0] RSEL_PC   = 3'd3;
  localparam logic [2:0] RSEL_LINK = 3'd4;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;
  localparam logic [5:0] FN_SLT = 6'h2A;

  localparam logic [5:0] OP_ADDI = 6'h08;
  localparam logic [5:0] OP_SLTI = 6'h0A;
  localparam logic [5:0] OP_ANDI = 6'h0C;
  localparam logic [5:0] OP_ORI  = 6'h0D;
  localparam logic [5:0] OP_XORI = 6'h0E;
endpackage

// File: rtl/ubus_regfile.sv
`timescale 1ns/1ps
module ubus_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      sel,
  input  logic [14:0]     fields,
  input  logic            wr,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] rdata
);
  import ubus_pkg::*;
  localparam int IW = $clog2(NREG + 1);
  localparam logic [IW-1:0] PC_IDX   = IW'(NREG);
  localparam logic [IW-1:0] LINK_IDX = IW'(NREG - 1);

  logic [XLEN-1:0] rf [0:NREG];
  logic [IW-1:0]   idx;

  always_comb begin
    case (sel)
      RSEL_RS:   idx = IW'(fields[14:10]);
      RSEL_RT:   idx = IW'(fields[9:5]);
      RSEL_RD:   idx = IW'(fields[4:0]);
      RSEL_PC:   idx = PC_IDX;
      RSEL_LINK: idx = LINK_IDX;
      default:   idx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i <= NREG; i++) rf[i] <= '0;
    end else if (wr && idx != '0) begin
      rf[idx] <= wdata;
    end
  end

  assign rdata = (idx == '0) ? '0 : rf[idx];

  // R4
  pc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == RSEL_PC) |=> (rf[PC_IDX] == $past(wdata)));
endmodule

// File: rtl/ubus_alu.sv
`timescale 1ns/1ps
module ubus_alu #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [1:0]      op,
  input  logic [5:0]      opcode,
  input  logic [5:0]      funct,
  output logic [XLEN-1:0] y
);
  import ubus_pkg::*;
  typedef enum logic [2:0] {K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_SLT} kind_e;

  kind_e           kind;
  logic [XLEN-1:0] decoded;
  logic            lt;

  assign lt = $signed(a) < $signed(b);

  always_comb begin
    kind = K_ADD;
    if (opcode == 6'd0) begin
      case (funct)
        FN_SUB:  kind = K_SUB;
        FN_AND:  kind = K_AND;
        FN_OR:   kind = K_OR;
        FN_XOR:  kind = K_XOR;
        FN_SLT:  kind = K_SLT;
        default: kind = K_ADD;
      endcase
    end else begin
      case (opcode)
        OP_ANDI: kind = K_AND;
        OP_ORI:  kind = K_OR;
        OP_XORI: kind = K_XOR;
        OP_SLTI: kind = K_SLT;
        default: kind = K_ADD;
      endcase
    end
  end

  always_comb begin
    case (kind)
      K_SUB:   decoded = a - b;
      K_AND:   decoded = a & b;
      K_OR:    decoded = a | b;
      K_XOR:   decoded = a ^ b;
      K_SLT:   decoded = XLEN'(lt);
      default: decoded = a + b;
    endcase
  end

  always_comb begin
    case (alu_op_e'(op))
      ALU_A:   y = a;
      ALU_B:   y = b;
      ALU_IR:  y = decoded;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/ubus_immext.sv
`timescale 1ns/1ps
module ubus_immext #(
  parameter int XLEN = 32,
  parameter int IMMW = 16
) (
  input  logic [IMMW-1:0] imm,
  input  logic [3:0]      a_top,
  input  logic [25:0]     b_low,
  input  logic [1:0]      sel,
  output logic [XLEN-1:0] y
);
  import ubus_pkg::*;
  logic [XLEN-1:0] sx;
  assign sx = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};

  always_comb begin
    case (imm_sel_e'(sel))
      IMM_ZEXT:  y = {{(XLEN-IMMW){1'b0}}, imm};
      IMM_SEXT4: y = sx << 2;
      IMM_JUMP:  y = XLEN'({a_top, b_low, 2'b00});
      default:   y = sx;
    endcase
  end
endmodule

// File: rtl/ubus_wordmem.sv
`timescale 1ns/1ps
module ubus_wordmem #(
  parameter int XLEN  = 32,
  parameter int WORDS = 1024,
  parameter int LAT   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  logic                     we,
  input  logic [$clog2(WORDS)-1:0] addr,
  input  logic [XLEN-1:0]          wdata,
  output logic [XLEN-1:0]          rdata,
  output logic                     busy
);
  localparam int AW = $clog2(WORDS);
  localparam int CW = $clog2(LAT + 1);

  logic [XLEN-1:0] mem [0:WORDS-1];
  logic [CW-1:0]   cnt;
  logic [AW-1:0]   addr_q;
  logic            we_q;
  logic [XLEN-1:0] wdata_q;
  logic            finish;

  assign busy   = (cnt != '0);
  assign finish = (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      rdata   <= '0;
    end else if (!busy) begin
      if (req) begin
        cnt     <= CW'(LAT);
        addr_q  <= addr;
        we_q    <= we;
        wdata_q <= wdata;
      end
    end else begin
      cnt <= cnt - CW'(1);
      if (finish && !we_q) rdata <= mem[addr_q];
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && finish && we_q) mem[addr_q] <= wdata_q;
  end

  // R9
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req));

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_q));
endmodule

// File: rtl/ubus_datapath.sv
`timescale 1ns/1ps
module ubus_datapath #(
  parameter int XLEN      = 32,
  parameter int NREG      = 32,
  parameter int MEM_WORDS = 1024,
  parameter int MEM_LAT   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            drv_mem,
  input  logic            drv_reg,
  input  logic            drv_alu,
  input  logic            drv_imm,
  input  logic            drv_host,
  input  logic [XLEN-1:0] host_data,
  input  logic            cap_a,
  input  logic            cap_b,
  input  logic            cap_ma,
  input  logic            cap_ir,
  input  logic [2:0]      reg_sel,
  input  logic            reg_wr,
  input  logic [1:0]      imm_sel,
  input  logic [1:0]      alu_op,
  input  logic            mem_req,
  input  logic            mem_we,
  output logic [5:0]      opcode,
  output logic            a_zero,
  output logic            mem_busy,
  output logic [XLEN-1:0] bus
);
  localparam int AW = $clog2(MEM_WORDS);

  logic [XLEN-1:0] a_q, b_q, ma_q, ir_q;
  logic [XLEN-1:0] rf_out, alu_out, imm_out, mem_out;
  logic            unused_bits;

  assign unused_bits = ^{ma_q[XLEN-1:AW+2], ma_q[1:0], ir_q[10:6], b_q[XLEN-1:26], a_q[27:0]};

  // Wired bus: each source gated by its own enable.
  assign bus = ({XLEN{drv_mem}}  & mem_out)
             | ({XLEN{drv_reg}}  & rf_out)
             | ({XLEN{drv_alu}}  & alu_out)
             | ({XLEN{drv_imm}}  & imm_out)
             | ({XLEN{drv_host}} & host_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q  <= '0;
      b_q  <= '0;
      ma_q <= '0;
      ir_q <= '0;
    end else begin
      if (cap_a)  a_q  <= bus;
      if (cap_b)  b_q  <= bus;
      if (cap_ma) ma_q <= bus;
      if (cap_ir) ir_q <= bus;
    end
  end

  assign opcode = ir_q[31:26];
  assign a_zero = (a_q == '0);

  ubus_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (reg_sel),
    .fields (ir_q[25:11]),
    .wr     (reg_wr),
    .wdata  (bus),
    .rdata  (rf_out)
  );

  ubus_alu #(.XLEN(XLEN)) u_alu (
    .a      (a_q),
    .b      (b_q),
    .op     (alu_op),
    .opcode (ir_q[31:26]),
    .funct  (ir_q[5:0]),
    .y      (alu_out)
  );

  ubus_immext #(.XLEN(XLEN), .IMMW(16)) u_imm (
    .imm   (ir_q[15:0]),
    .a_top (a_q[31:28]),
    .b_low (b_q[25:0]),
    .sel   (imm_sel),
    .y     (imm_out)
  );

  ubus_wordmem #(.XLEN(XLEN), .WORDS(MEM_WORDS), .LAT(MEM_LAT)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (mem_req),
    .we    (mem_we),
    .addr  (ma_q[AW+1:2]),
    .wdata (bus),
    .rdata (mem_out),
    .busy  (mem_busy)
  );

  // R2
  bus_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drv_mem, drv_reg, drv_alu, drv_imm, drv_host}));

  // R11
  opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ir |=> (opcode == $past(bus[31:26])));
endmodule

// File: tb/ubus_datapath_tb.sv
`timescale 1ns/1ps
module ubus_datapath_tb;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        drv_mem, drv_reg, drv_alu, drv_imm, drv_host;
  logic [31:0] host_data;
  logic        cap_a, cap_b, cap_ma, cap_ir;
  logic [2:0]  reg_sel;
  logic        reg_wr;
  logic [1:0]  imm_sel, alu_op;
  logic        mem_req, mem_we;
  logic [5:0]  opcode;
  logic        a_zero, mem_busy;
  logic [31:0] bus;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ubus_datapath #(.MEM_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .drv_mem(drv_mem), .drv_reg(drv_reg), .drv_alu(drv_alu), .drv_imm(drv_imm),
    .drv_host(drv_host), .host_data(host_data),
    .cap_a(cap_a), .cap_b(cap_b), .cap_ma(cap_ma), .cap_ir(cap_ir),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .imm_sel(imm_sel), .alu_op(alu_op),
    .mem_req(mem_req), .mem_we(mem_we),
    .opcode(opcode), .a_zero(a_zero), .mem_busy(mem_busy), .bus(bus)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic idle();
    drv_mem = 0; drv_reg = 0; drv_alu = 0; drv_imm = 0; drv_host = 0;
    cap_a = 0; cap_b = 0; cap_ma = 0; cap_ir = 0; reg_wr = 0;
    mem_req = 0; mem_we = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  // which: 0=A 1=B 2=MA 3=IR
  task automatic host_cap(input logic [31:0] v, input int which);
    tick();
    drv_host = 1; host_data = v;
    cap_a = (which == 0); cap_b = (which == 1);
    cap_ma = (which == 2); cap_ir = (which == 3);
  endtask

  task automatic host_wr(input logic [2:0] sel, input logic [31:0] v);
    tick();
    drv_host = 1; host_data = v; reg_sel = sel; reg_wr = 1;
  endtask

  task automatic peek_reg(input logic [2:0] sel);
    tick(); drv_reg = 1; reg_sel = sel; #2;
  endtask

  task automatic peek_alu(input logic [1:0] op);
    tick(); drv_alu = 1; alu_op = op; #2;
  endtask

  task automatic peek_imm(input logic [1:0] sel);
    tick(); drv_imm = 1; imm_sel = sel; #2;
  endtask

  // Start an access, count busy cycles; optionally issue a second request while busy.
  task automatic mem_op(input logic we, input logic [31:0] v, input bit poke, output int n);
    bit first = 1'b1;
    tick();
    drv_host = we; host_data = v; mem_req = 1; mem_we = we;
    n = 0;
    for (int k = 0; k < 20; k++) begin
      tick(); #2;
      if (!mem_busy) break;
      n++;
      if (first && poke) begin
        drv_host = 1; host_data = ~v; mem_req = 1; mem_we = 1;
      end
      first = 1'b0;
    end
  endtask

  function automatic logic [31:0] rval(input int i);
    return 32'hA500_0000 ^ (i * 32'h0101_0101) ^ 32'(i + 7);
  endfunction

  function automatic logic [31:0] alu_model(input logic [1:0] op, input logic [31:0] a,
                                            input logic [31:0] b, input logic [31:0] ir);
    logic [5:0] opc, fn;
    logic [31:0] slt;
    opc = ir[31:26]; fn = ir[5:0];
    slt = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    case (op)
      2'd0: return a + b;
      2'd1: return a;
      2'd2: return b;
      default: begin
        if (opc == 6'd0) begin
          case (fn)
            6'h22: return a - b;
            6'h24: return a & b;
            6'h25: return a | b;
            6'h26: return a ^ b;
            6'h2A: return slt;
            default: return a + b;
          endcase
        end else begin
          case (opc)
            6'h0C: return a & b;
            6'h0D: return a | b;
            6'h0E: return a ^ b;
            6'h0A: return slt;
            default: return a + b;
          endcase
        end
      end
    endcase
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] pa [5];
    logic [31:0] pb [5];
    logic [5:0]  fns [7];
    logic [5:0]  ops [6];
    logic [15:0] imms [6];
    int n;
    pa = '{32'h0, 32'h7FFF_FFFF, 32'h8000_0000, 32'h1234_5678, 32'hFFFF_FFFF};
    pb = '{32'h0000_0001, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0F0F_F0F0, 32'hFFFF_FFFF};
    fns = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h2A, 6'h3F};
    ops = '{6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h0E, 6'h23};
    imms = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};

    idle(); host_data = 0; reg_sel = 0; imm_sel = 0; alu_op = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    tick(); #2;
    check("R1 idle bus", bus, 32'h0);
    check("R1 busy", {31'h0, mem_busy}, 32'h0);
    check("R1 a_zero", {31'h0, a_zero}, 32'h1);
    check("R1 opcode", {26'h0, opcode}, 32'h0);
    peek_reg(3'd3); check("R1 pc", bus, 32'h0);
    peek_alu(2'd1); check("R1 A", bus, 32'h0);
    peek_alu(2'd2); check("R1 B", bus, 32'h0);

    // R3 / R2 / R8 latch capture through the bus
    foreach (pa[i]) begin
      host_cap(pa[i], 0);
      host_cap(pb[i], 1);
      peek_alu(2'd1); check("R3 A capture", bus, pa[i]);
      check("R8 a_zero", {31'h0, a_zero}, {31'h0, pa[i] == 32'h0});
      peek_alu(2'd2); check("R3 B capture", bus, pb[i]);
      tick(); drv_host = 1; host_data = pa[i] ^ 32'h5A5A_5A5A; #2;
      check("R2 host drives bus", bus, pa[i] ^ 32'h5A5A_5A5A);
    end

    // R4 / R5 register select sweep: write through rs field
    for (int i = 0; i < 32; i++) begin
      host_cap({6'h0, 5'(i), 21'h0}, 3);
      host_wr(3'd0, rval(i));
    end
    for (int i = 0; i < 32; i++) begin
      host_cap({6'h0, 5'd0, 5'(i), 16'h0}, 3);
      peek_reg(3'd1);
      check((i == 0) ? "R5 r0 via rt" : "R4 read via rt", bus, (i == 0) ? 32'h0 : rval(i));
      host_cap({16'h0, 5'(i), 11'h0}, 3);
      peek_reg(3'd2);
      check("R4 read via rd", bus, (i == 0) ? 32'h0 : rval(i));
    end
    host_wr(3'd3, 32'hC0DE_0040);
    peek_reg(3'd3); check("R4 pc entry", bus, 32'hC0DE_0040);
    peek_reg(3'd4); check("R4 link is r31", bus, rval(31));
    host_wr(3'd4, 32'h1111_2222);
    peek_reg(3'd4); check("R4 link write", bus, 32'h1111_2222);
    peek_reg(3'd3); check("R4 pc untouched by link", bus, 32'hC0DE_0040);
    host_wr(3'd6, 32'hDEAD_BEEF);
    peek_reg(3'd6); check("R5 sel6 entry 0 reads 0", bus, 32'h0);
    peek_reg(3'd4); check("R5 sel6 write no effect on r31", bus, 32'h1111_2222);

    // R6 immediate forms
    foreach (imms[i]) begin
      host_cap({6'h0D, 5'd3, 5'd4, imms[i]}, 3);
      peek_imm(2'd0); check("R6 sext", bus, {{16{imms[i][15]}}, imms[i]});
      peek_imm(2'd1); check("R6 zext", bus, {16'h0, imms[i]});
      peek_imm(2'd2); check("R6 sext<<2", bus, {{14{imms[i][15]}}, imms[i], 2'b00});
    end
    foreach (pa[i]) begin
      host_cap(pa[i] ^ 32'hA000_0000, 0);
      host_cap(pb[i], 1);
      peek_imm(2'd3);
      check("R6 jump target", bus, {pa[i][31:28] ^ 4'hA, pb[i][25:0], 2'b00});
    end

    // R7 ALU sweep, R11 opcode
    foreach (pa[i]) begin
      foreach (pb[j]) begin
        host_cap(pa[i], 0);
        host_cap(pb[j], 1);
        for (int op = 0; op < 3; op++) begin
          peek_alu(2'(op));
          check("R7 alu basic", bus, alu_model(2'(op), pa[i], pb[j], 32'h0));
        end
        foreach (fns[k]) begin
          host_cap({6'h0, 5'd1, 5'd2, 5'd3, 5'd0, fns[k]}, 3);
          peek_alu(2'd3);
          check("R7 alu funct", bus, alu_model(2'd3, pa[i], pb[j], {26'h0, fns[k]}));
        end
        foreach (ops[k]) begin
          host_cap({ops[k], 5'd1, 5'd2, 16'h0}, 3);
          peek_alu(2'd3);
          check("R11 opcode", {26'h0, opcode}, {26'h0, ops[k]});
          check("R7 alu opcode", bus, alu_model(2'd3, pa[i], pb[j], {ops[k], 26'h0}));
        end
      end
    end

    // R9 / R10 memory
    host_cap(32'h0000_0040, 2);
    mem_op(1'b1, 32'hCAFE_0001, 1'b0, n);
    check("R9 write busy length", 32'(n), 32'(LAT));
    host_cap(32'h0000_0043, 2);
    mem_op(1'b0, 32'h0, 1'b0, n);
    check("R9 read busy length", 32'(n), 32'(LAT));
    tick(); drv_mem = 1; #2;
    check("R10 read low bits ignored", bus, 32'hCAFE_0001);

    host_cap(32'h0000_0080, 2);
    mem_op(1'b1, 32'h1357_9BDF, 1'b1, n);
    check("R9 busy not extended by request while busy", 32'(n), 32'(LAT));
    tick(); #2;
    check("R9 no second access started", {31'h0, mem_busy}, 32'h0);
    mem_op(1'b0, 32'h0, 1'b0, n);
    tick(); drv_mem = 1; #2;
    check("R9 request while busy ignored", bus, 32'h1357_9BDF);

    for (int w = 0; w < 8; w++) begin
      host_cap(32'(w * 4 + 32'h200), 2);
      mem_op(1'b1, 32'h600D_0000 + 32'(w * 3), 1'b0, n);
    end
    for (int w = 7; w >= 0; w--) begin
      host_cap(32'(w * 4 + 32'h200) | 32'(w & 3), 2);
      mem_op(1'b0, 32'h0, 1'b0, n);
      tick(); drv_mem = 1; #2;
      check("R10 word readback", bus, 32'h600D_0000 + 32'(w * 3));
    end
    host_cap(32'h0000_0080, 2);
    mem_op(1'b0, 32'h0, 1'b0, n);
    tick(); drv_mem = 1; #2;
    check("R10 earlier word intact", bus, 32'h1357_9BDF);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule